// File: doc/BRIEF.md
# Buffer Flush Request Handshake

This block lets an agent on the I/O side ask the memory controller to empty its internal buffers, and tells that agent when the buffers are empty. When the active-low flush request is seen, the block stops admitting ordinary new transactions from the host side. Snoop copy-backs are still admitted so that coherency traffic keeps moving. The block tracks the number of outstanding transactions with a counter, which is fed by issue and completion pulses. When that count reaches zero, the block drives the active-low acknowledge.

The acknowledge stays asserted for a fixed window after the requester lets go of the request. A new request seen inside that window is reported on a protocol-error output and is otherwise ignored. Host admission reopens on the same clock edge that releases the acknowledge.

Top module: `flush_handshake`

## Requirements
- R1: After a synchronous reset, `flush_ack_n` is 1, `proto_err` is 0, the outstanding count is zero, and ordinary host transactions are accepted.
- R2: `flush_req_n` is registered once. From the second rising edge after it is first sampled low, `host_accept` is 0 for any `host_valid` with `host_copyback` = 0. This lasts until the acknowledge is released.
- R3: A host transaction with `host_copyback` = 1 is always accepted (`host_accept` = `host_valid`), including while a flush drains or is acknowledged.
- R4: With the request held, `flush_ack_n` goes to 0 on the rising edge after the one that brings the outstanding count to zero. It is never 0 while transactions are outstanding.
- R5: Once the acknowledge is low, it stays low until the third rising edge after the one that first samples `flush_req_n` high. That is two release cycles after the request register drops.
- R6: Ordinary host acceptance resumes on the same edge at which `flush_ack_n` returns to 1.
- R7: If the request is seen again during the release window, `proto_err` is 1 for each edge that follows a release cycle with the request present. The release completes on schedule, and a new flush starts only from idle.
- R8: The outstanding count rises by one on `txn_issue` and falls by one on `txn_done`. Both pulses together leave it unchanged, and an issue pulse in the same cycle as a zero count holds off the acknowledge.
- R9: If the request is withdrawn while transactions are still draining, the block returns to idle without ever asserting `flush_ack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req_n | input | 1 | Flush request, active low |
| flush_ack_n | output | 1 | Flush acknowledge, active low, registered |
| host_valid | input | 1 | A new host-side transaction is offered |
| host_copyback | input | 1 | The offered transaction is a snoop copy-back |
| host_accept | output | 1 | The offered transaction is admitted |
| txn_issue | input | 1 | Pulse: one transaction became outstanding |
| txn_done | input | 1 | Pulse: one outstanding transaction completed |
| proto_err | output | 1 | Request was reasserted inside the release window |

## Verification
The hardest situation to reach is a request that comes back inside the two-cycle release window. The bench negates the request for exactly one cycle after the acknowledge and then drives it low again. The registered request therefore arrives while the release count is running. A second hard case is a copy-back issued mid-drain: the bench raises the count again after some completions and checks that the acknowledge waits for the extra completion.

// File: rtl/flush_hs_pkg.sv
package flush_hs_pkg;
  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_DRAIN   = 2'd1,
    FS_ACK     = 2'd2,
    FS_RELEASE = 2'd3
  } flush_state_e;
endpackage

// File: rtl/flush_req_reg.sv
module flush_req_reg (
  input  logic clk,
  input  logic rst,
  input  logic req_n_i,
  output logic req_act_o
);
  // Convert the active-low pin to active-high and register it once.
  always_ff @(posedge clk) begin
    if (rst) req_act_o <= 1'b0;
    else     req_act_o <= ~req_n_i;
  end
endmodule

// File: rtl/flush_pend_ctr.sv
module flush_pend_ctr #(
  parameter int MAX_OUT = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i && cnt_q != CNT_W'(MAX_OUT)) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R8: the count must not be pushed past its capacity or below zero.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !dec_i) |-> (cnt_q != CNT_W'(MAX_OUT)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !inc_i) |-> (cnt_q != '0));
  assert_pair_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (inc_i && dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/flush_hs_fsm.sv
module flush_hs_fsm
  import flush_hs_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_act_i,
  input  logic         pend_zero_i,
  input  logic         issue_i,
  output flush_state_e state_o,
  output logic         ack_n_o,
  output logic         admit_o,
  output logic         proto_err_o
);
  localparam int REL_W = $clog2(HOLD_CYC + 1);

  flush_state_e     state_q, state_d;
  logic [REL_W-1:0] rel_q;
  logic             rel_last;

  assign rel_last = (rel_q == REL_W'(HOLD_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE:    if (req_act_i) state_d = FS_DRAIN;
      FS_DRAIN: begin
        if (!req_act_i)                    state_d = FS_IDLE;
        else if (pend_zero_i && !issue_i)  state_d = FS_ACK;
      end
      FS_ACK:     if (!req_act_i) state_d = FS_RELEASE;
      FS_RELEASE: if (rel_last)   state_d = FS_IDLE;
      default:    state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= FS_IDLE;
      rel_q       <= '0;
      ack_n_o     <= 1'b1;
      admit_o     <= 1'b1;
      proto_err_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      rel_q       <= (state_q == FS_RELEASE) ? rel_q + 1'b1 : '0;
      ack_n_o     <= !(state_d == FS_ACK || state_d == FS_RELEASE);
      admit_o     <= (state_d == FS_IDLE);
      proto_err_o <= (state_q == FS_RELEASE) && req_act_i;
    end
  end

  assign state_o = state_q;

  // R5: the acknowledge is released only after two release cycles.
  assert_hold_window_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n_o) |-> ($past(state_q) == FS_RELEASE && $past(state_q, 2) == FS_RELEASE));
  // R7: an error flag is raised only from the release window.
  assert_err_source_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |-> ($past(state_q) == FS_RELEASE));
  // R7: a request seen in release never jumps straight back to draining.
  assert_release_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_RELEASE) |=> (state_q != FS_DRAIN));
  // R9: a withdrawn drain never produces an acknowledge.
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_DRAIN && !req_act_i) |=> ack_n_o);
endmodule

// File: rtl/flush_handshake.sv
module flush_handshake
  import flush_hs_pkg::*;
#(
  parameter int MAX_OUT  = 15,
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_req_n,
  output logic flush_ack_n,
  input  logic host_valid,
  input  logic host_copyback,
  output logic host_accept,
  input  logic txn_issue,
  input  logic txn_done,
  output logic proto_err
);
  logic         req_act;
  logic         pend_zero;
  logic         admit_open;
  flush_state_e fsm_state;

  flush_req_reg u_req (
    .clk       (clk),
    .rst       (rst),
    .req_n_i   (flush_req_n),
    .req_act_o (req_act)
  );

  flush_pend_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (txn_issue),
    .dec_i  (txn_done),
    .zero_o (pend_zero)
  );

  flush_hs_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_act_i   (req_act),
    .pend_zero_i (pend_zero),
    .issue_i     (txn_issue),
    .state_o     (fsm_state),
    .ack_n_o     (flush_ack_n),
    .admit_o     (admit_open),
    .proto_err_o (proto_err)
  );

  // Copy-backs bypass the admission gate; ordinary traffic needs it open.
  assign host_accept = host_valid & (admit_open | host_copyback);

  // R2: ordinary transactions are blocked while draining or acknowledged.
  assert_block_ordinary_R2: assert property (@(posedge clk) disable iff (rst)
    ((fsm_state == FS_DRAIN || fsm_state == FS_ACK) && host_valid && !host_copyback)
      |-> !host_accept);
  // R4: the acknowledge falls only when nothing was outstanding.
  assert_ack_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_ack_n) |-> $past(pend_zero));
  // R6: admission reopens together with the acknowledge release.
  assert_resume_with_ack_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_ack_n) |-> admit_open);
endmodule

// File: tb/flush_handshake_tb_top.sv
module flush_handshake_tb_top;
  logic clk = 1'b0;
  logic rst, flush_req_n, host_valid, host_copyback, txn_issue, txn_done;
  logic flush_ack_n, host_accept, proto_err;
  int   n_checks = 0;
  int   n_fail   = 0;

  always #5 clk = ~clk;

  flush_handshake dut_i (
    .clk(clk), .rst(rst), .flush_req_n(flush_req_n), .flush_ack_n(flush_ack_n),
    .host_valid(host_valid), .host_copyback(host_copyback), .host_accept(host_accept),
    .txn_issue(txn_issue), .txn_done(txn_done), .proto_err(proto_err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue_n(input int n);
    for (int i = 0; i < n; i++) begin
      txn_issue = 1'b1; step(); txn_issue = 1'b0;
    end
  endtask

  // Release phase from an acknowledged state: request goes high now.
  task automatic release_flush(input string tag);
    flush_req_n = 1'b1;
    step(); chk({tag, " R5 low A"}, flush_ack_n, 1'b0);
    step(); chk({tag, " R5 low A+1"}, flush_ack_n, 1'b0);
    step(); chk({tag, " R5 low A+2"}, flush_ack_n, 1'b0);
            chk({tag, " R2 still blocked"}, host_accept, 1'b0);
    step(); chk({tag, " R5 released A+3"}, flush_ack_n, 1'b1);
            chk({tag, " R6 resume"}, host_accept, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1; flush_req_n = 1'b1; host_valid = 1'b1; host_copyback = 1'b0;
    txn_issue = 1'b0; txn_done = 1'b0;
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 ack idle", flush_ack_n, 1'b1);
    chk("R1 err idle", proto_err, 1'b0);
    chk("R1 accept open", host_accept, 1'b1);
  endtask

  task automatic t_empty_flush();
    flush_req_n = 1'b0;
    step(); chk("R2 open after E1", host_accept, 1'b1);
    step(); chk("R2 blocked after E2", host_accept, 1'b0);
            chk("R4 no ack yet", flush_ack_n, 1'b1);
    step(); chk("R4 ack empty", flush_ack_n, 1'b0);
    release_flush("empty");
  endtask

  task automatic t_drain_multi();
    issue_n(3);
    flush_req_n = 1'b0;
    step(); step();
    chk("R4 waiting cnt3", flush_ack_n, 1'b1);
    txn_done = 1'b1;
    step(); chk("R4 waiting cnt2", flush_ack_n, 1'b1);
    step(); chk("R4 waiting cnt1", flush_ack_n, 1'b1);
    step(); chk("R4 cnt0 edge", flush_ack_n, 1'b1);
    txn_done = 1'b0;
    step(); chk("R4 ack after drain", flush_ack_n, 1'b0);
    release_flush("drain");
  endtask

  task automatic t_copyback();
    issue_n(2);
    flush_req_n = 1'b0;
    step(); step();
    host_copyback = 1'b1; #1;
    chk("R3 copyback in drain", host_accept, 1'b1);
    host_copyback = 1'b0; #1;
    chk("R2 ordinary in drain", host_accept, 1'b0);
    txn_done = 1'b1; step();            // count 1
    txn_done = 1'b0; txn_issue = 1'b1;  // copy-back issued: count 2
    step(); txn_issue = 1'b0;
    chk("R8 extra copyback holds ack", flush_ack_n, 1'b1);
    txn_done = 1'b1; txn_issue = 1'b1;  // simultaneous: stays 2
    step(); txn_issue = 1'b0;
    step();                             // count 1
    chk("R8 pair no change", flush_ack_n, 1'b1);
    step(); txn_done = 1'b0;            // count 0
    chk("R8 zero edge", flush_ack_n, 1'b1);
    step(); chk("R4 ack after copyback", flush_ack_n, 1'b0);
    host_copyback = 1'b1; #1;
    chk("R3 copyback in ack", host_accept, 1'b1);
    host_copyback = 1'b0;
    release_flush("copyback");
  endtask

  task automatic t_early_reassert();
    flush_req_n = 1'b0;
    step(); step(); step();
    chk("R7 setup ack", flush_ack_n, 1'b0);
    flush_req_n = 1'b1;
    step();                              // A
    flush_req_n = 1'b0;
    step(); chk("R7 no err A+1", proto_err, 1'b0);
            chk("R7 ack A+1", flush_ack_n, 1'b0);
    step(); chk("R7 err A+2", proto_err, 1'b1);
            chk("R7 ack A+2", flush_ack_n, 1'b0);
    step(); chk("R7 ack released A+3", flush_ack_n, 1'b1);
            chk("R7 err A+3", proto_err, 1'b1);
    step(); chk("R7 err clears", proto_err, 1'b0);
            chk("R7 new drain blocks", host_accept, 1'b0);
    step(); chk("R7 new ack", flush_ack_n, 1'b0);
    release_flush("reassert");
  endtask

  task automatic t_abort();
    issue_n(1);
    flush_req_n = 1'b0;
    step(); step();
    chk("R9 draining", host_accept, 1'b0);
    flush_req_n = 1'b1;
    step(); chk("R9 no ack", flush_ack_n, 1'b1);
    step(); chk("R9 idle no ack", flush_ack_n, 1'b1);
            chk("R9 reopened", host_accept, 1'b1);
    txn_done = 1'b1; step(); txn_done = 1'b0;
    step(); chk("R9 stays idle", flush_ack_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_empty_flush();
    t_drain_multi();
    t_copyback();
    t_early_reassert();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule